// File: doc/BRIEF.md
# Dual-Destination Compare and Predicated Execute Unit

This block gives a statically scheduled datapath branch-free conditional execution. It holds a small file of one-bit predicates. It also accepts one compare and one ALU operation in every cycle. The compare checks two integer operands against a condition and sets two predicates in the same operation. One predicate receives the outcome and the other receives its inverse, so both arms of an if/else have a guard ready from a single compare.

Each ALU operation names a guard predicate. When that guard reads 1, the result is written back one cycle later on the write-back port. When the guard reads 0, the operation leaves no trace: no write-back takes place. Predicate 0 always reads 1, so an operation that should always run names it as its guard. A compare updates the predicates at the clock edge. An ALU operation issued in the same cycle as the compare therefore still sees the old predicate values. The whole predicate file is visible on an output so that its state can be observed.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset, `pred_vec` equals 8'h01 (predicate 0 set, all others clear) and `wb_valid` is 0.
- R2: Predicate 0 always reads 1. A compare that names predicate 0 as either destination leaves it at 1.
- R3: The compare condition codes are 0 = equal, 1 = not equal, 2 = signed less-than, 3 = signed greater-than and 4 = unsigned less-than, each testing `cmp_src_a` against `cmp_src_b`. Codes 5 to 7 give an outcome of 0.
- R4: With `cmp_valid` high, predicate `cmp_dst_t` takes the outcome and predicate `cmp_dst_f` takes its inverse. Both values appear on `pred_vec` after the next rising clock edge.
- R5: When `cmp_dst_t` equals `cmp_dst_f` (and is not 0), that predicate takes the inverse of the outcome.
- R6: Predicates that the compare does not name keep their values. When `cmp_valid` is low, no predicate changes.
- R7: With `ex_valid` high and the guard predicate at 1, the clock edge after issue brings `wb_valid` high, `wb_dst` = `ex_dst`, and `wb_data` = the result of `ex_op`. The op codes are 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 move a, 6 move b, 7 shift a left by b[4:0].
- R8: With the guard predicate at 0, or with `ex_valid` low, `wb_valid` is 0 on the following cycle.
- R9: An ALU operation that issues in the same cycle as a compare which rewrites its guard is gated by the guard value from before that compare.
- R10: A compare followed by a move-a guarded by the true destination and a move-b guarded by the false destination writes exactly one of the two operands: the greater one under a signed greater-than compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare issues this cycle |
| cmp_cond | input | 3 | Condition code |
| cmp_src_a | input | 32 | First compare operand |
| cmp_src_b | input | 32 | Second compare operand |
| cmp_dst_t | input | 3 | Predicate that receives the outcome |
| cmp_dst_f | input | 3 | Predicate that receives the inverse |
| ex_valid | input | 1 | ALU operation issues this cycle |
| ex_op | input | 3 | ALU op code |
| ex_src_a | input | 32 | First ALU operand |
| ex_src_b | input | 32 | Second ALU operand |
| ex_dst | input | 4 | Destination register index |
| ex_guard | input | 3 | Guard predicate index |
| wb_valid | output | 1 | Write-back is valid |
| wb_dst | output | 4 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| pred_vec | output | 8 | Current predicate file contents |

## Verification
Random operands are mixed with operand pairs that are equal, that differ only in sign, and that hold the extreme signed and unsigned values. These pairs separate signed from unsigned ordering and strict from non-strict comparison. Random destination pairs include the same index twice and index 0, which shows the write order and the hardwired predicate. Compares and guarded operations are also issued in the same cycle on a shared predicate, which separates old-value gating from forwarding. A directed max sequence shows that the if/else pair writes exactly once.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        CND_EQ  = 3'd0,
        CND_NE  = 3'd1,
        CND_LT  = 3'd2,
        CND_GT  = 3'd3,
        CND_LTU = 3'd4
    } cond_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MOVA = 3'd5,
        OP_MOVB = 3'd6,
        OP_SHL  = 3'd7
    } aluop_e;
endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        cond,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              outcome
);
    import pcu_pkg::*;

    always_comb begin
        unique case (cond)
            CND_EQ:  outcome = (src_a == src_b);
            CND_NE:  outcome = (src_a != src_b);
            CND_LT:  outcome = ($signed(src_a) < $signed(src_b));
            CND_GT:  outcome = ($signed(src_a) > $signed(src_b));
            CND_LTU: outcome = (src_a < src_b);
            default: outcome = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcu_alu.sv
module pcu_alu #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result
);
    import pcu_pkg::*;
    localparam int SH_W = $clog2(DATA_W);

    always_comb begin
        unique case (op)
            OP_ADD:  result = src_a + src_b;
            OP_SUB:  result = src_a - src_b;
            OP_AND:  result = src_a & src_b;
            OP_OR:   result = src_a | src_b;
            OP_XOR:  result = src_a ^ src_b;
            OP_MOVA: result = src_a;
            OP_MOVB: result = src_b;
            default: result = src_a << src_b[SH_W-1:0];
        endcase
    end
endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file #(
    parameter int NUM_PRED = 8,
    localparam int PIDX_W = $clog2(NUM_PRED)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PIDX_W-1:0]   dst_t,
    input  logic [PIDX_W-1:0]   dst_f,
    input  logic                outcome,
    input  logic [PIDX_W-1:0]   rd_idx,
    output logic                rd_val,
    output logic [NUM_PRED-1:0] pred_vec
);
    typedef struct packed {
        logic [NUM_PRED-1:0] bits;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits[dst_t] = outcome;
            st_d.bits[dst_f] = ~outcome;   // applied last: inverse wins on a clash
        end
        st_d.bits[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bits <= {{(NUM_PRED-1){1'b0}}, 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_val   = st_q.bits[rd_idx];
    assign pred_vec = st_q.bits;

    assert_p0_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_vec[0] == 1'b1);

    assert_true_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && dst_t != '0 && dst_t != dst_f |=> pred_vec[$past(dst_t)] == $past(outcome));

    assert_false_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && dst_f != '0 |=> pred_vec[$past(dst_f)] == !$past(outcome));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pred_vec));
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
    parameter int DATA_W   = 32,
    parameter int NUM_PRED = 8,
    parameter int NUM_GPR  = 16,
    localparam int PIDX_W  = $clog2(NUM_PRED),
    localparam int RIDX_W  = $clog2(NUM_GPR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [2:0]          cmp_cond,
    input  logic [DATA_W-1:0]   cmp_src_a,
    input  logic [DATA_W-1:0]   cmp_src_b,
    input  logic [PIDX_W-1:0]   cmp_dst_t,
    input  logic [PIDX_W-1:0]   cmp_dst_f,
    input  logic                ex_valid,
    input  logic [2:0]          ex_op,
    input  logic [DATA_W-1:0]   ex_src_a,
    input  logic [DATA_W-1:0]   ex_src_b,
    input  logic [RIDX_W-1:0]   ex_dst,
    input  logic [PIDX_W-1:0]   ex_guard,
    output logic                wb_valid,
    output logic [RIDX_W-1:0]   wb_dst,
    output logic [DATA_W-1:0]   wb_data,
    output logic [NUM_PRED-1:0] pred_vec
);
    typedef struct packed {
        logic              valid;
        logic [RIDX_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } wb_t;

    logic              cmp_outcome;
    logic              guard_val;
    logic [DATA_W-1:0] alu_res;
    wb_t               wb_d, wb_q;

    pcu_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .cond    (cmp_cond),
        .src_a   (cmp_src_a),
        .src_b   (cmp_src_b),
        .outcome (cmp_outcome)
    );

    pcu_pred_file #(.NUM_PRED(NUM_PRED)) u_pfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_valid),
        .dst_t    (cmp_dst_t),
        .dst_f    (cmp_dst_f),
        .outcome  (cmp_outcome),
        .rd_idx   (ex_guard),
        .rd_val   (guard_val),
        .pred_vec (pred_vec)
    );

    pcu_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (ex_op),
        .src_a  (ex_src_a),
        .src_b  (ex_src_b),
        .result (alu_res)
    );

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = ex_valid && guard_val;
        if (ex_valid && guard_val) begin
            wb_d.dst  = ex_dst;
            wb_d.data = alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid = wb_q.valid;
    assign wb_dst   = wb_q.dst;
    assign wb_data  = wb_q.data;

    assert_guard_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_valid && pred_vec[ex_guard]) |=> !wb_valid);

    assert_guard_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && pred_vec[ex_guard] |=> wb_valid && wb_dst == $past(ex_dst));

    assert_blocked_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_valid && pred_vec[ex_guard]) |=> $stable(wb_data));
endmodule

// File: tb/tb_pred_cmp_unit.sv
module tb_pred_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_valid;
    logic [2:0]  cmp_cond;
    logic [31:0] cmp_src_a, cmp_src_b;
    logic [2:0]  cmp_dst_t, cmp_dst_f;
    logic        ex_valid;
    logic [2:0]  ex_op;
    logic [31:0] ex_src_a, ex_src_b;
    logic [3:0]  ex_dst;
    logic [2:0]  ex_guard;
    logic        wb_valid;
    logic [3:0]  wb_dst;
    logic [31:0] wb_data;
    logic [7:0]  pred_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_pred;
    int unsigned seed_val;

    always #5 clk = ~clk;

    pred_cmp_unit dut (.*);

    function automatic logic f_cmp(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) < $signed(b);
            3'd3: return $signed(a) > $signed(b);
            3'd4: return a < b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] f_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a;
            3'd6: return b;
            default: return a << b[4:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmp_valid = 0; cmp_cond = 0; cmp_src_a = 0; cmp_src_b = 0;
        cmp_dst_t = 0; cmp_dst_f = 0;
        ex_valid = 0; ex_op = 0; ex_src_a = 0; ex_src_b = 0; ex_dst = 0; ex_guard = 0;
    endtask

    // Inputs are already set at a falling edge; advance one cycle and check.
    task automatic step(input string req);
        logic exp_v;
        logic [31:0] exp_data;
        logic [3:0] exp_dst;
        logic o;
        exp_v    = ex_valid && m_pred[ex_guard];   // old value (R9)
        exp_data = f_alu(ex_op, ex_src_a, ex_src_b);
        exp_dst  = ex_dst;
        if (cmp_valid) begin
            o = f_cmp(cmp_cond, cmp_src_a, cmp_src_b);
            m_pred[cmp_dst_t] = o;
            m_pred[cmp_dst_f] = ~o;
        end
        m_pred[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({req, " pred R4 R6"}, {24'h0, pred_vec}, {24'h0, m_pred});
        check({req, " wb_valid R7 R8"}, {31'h0, wb_valid}, {31'h0, exp_v});
        if (exp_v) begin
            check({req, " wb_dst R7"}, {28'h0, wb_dst}, {28'h0, exp_dst});
            check({req, " wb_data R7"}, wb_data, exp_data);
        end
    endtask

    task automatic do_cmp(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] t, input logic [2:0] f);
        cmp_valid = 1; cmp_cond = c; cmp_src_a = a; cmp_src_b = b; cmp_dst_t = t; cmp_dst_f = f;
    endtask

    task automatic do_ex(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] d, input logic [2:0] g);
        ex_valid = 1; ex_op = op; ex_src_a = a; ex_src_b = b; ex_dst = d; ex_guard = g;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] edge_vals [6];
        seed_val = 32'd12345;
        void'($urandom(seed_val));
        edge_vals[0] = 32'h0; edge_vals[1] = 32'h1; edge_vals[2] = 32'hFFFF_FFFF;
        edge_vals[3] = 32'h7FFF_FFFF; edge_vals[4] = 32'h8000_0000; edge_vals[5] = 32'h8000_0001;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_pred = 8'h01;
        // R1 reset state
        check("R1 pred_vec", {24'h0, pred_vec}, 32'h1);
        check("R1 wb_valid", {31'h0, wb_valid}, 32'h0);

        // R2: unguarded via p0, and compare naming p0
        do_ex(3'd0, 32'd3, 32'd4, 4'd1, 3'd0); step("R2 p0 guard");
        do_ex(3'd0, 32'd3, 32'd4, 4'd1, 3'd2); step("R8 clear guard");
        idle(); do_cmp(3'd0, 32'd5, 32'd5, 3'd0, 3'd0); step("R2 p0 write");
        check("R2 p0 stays", {31'h0, pred_vec[0]}, 32'h1);

        // R3: each condition with signed vs unsigned split
        idle(); do_cmp(3'd2, 32'hFFFF_FFFF, 32'd1, 3'd1, 3'd2); step("R3 LT signed");
        idle(); do_cmp(3'd4, 32'hFFFF_FFFF, 32'd1, 3'd3, 3'd4); step("R3 LTU");
        idle(); do_cmp(3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 3'd5, 3'd6); step("R3 GT signed");
        idle(); do_cmp(3'd6, 32'd1, 32'd1, 3'd7, 3'd1); step("R3 reserved code");

        // R5: same destination -> inverse wins
        idle(); do_cmp(3'd0, 32'd9, 32'd9, 3'd3, 3'd3); step("R5 clash");
        check("R5 clash value", {31'h0, pred_vec[3]}, 32'h0);

        // R9: guard rewritten in same cycle uses old value
        idle(); do_cmp(3'd0, 32'd1, 32'd1, 3'd4, 3'd5); step("R9 setup");
        do_cmp(3'd1, 32'd1, 32'd1, 3'd4, 3'd5);
        do_ex(3'd5, 32'hABCD, 32'h0, 4'd7, 3'd4); step("R9 old true");
        do_cmp(3'd0, 32'd2, 32'd2, 3'd4, 3'd5);
        do_ex(3'd5, 32'h1234, 32'h0, 4'd8, 3'd4); step("R9 old false");

        // R10: max via compare and two guarded moves
        idle(); do_cmp(3'd3, 32'hFFFF_FFF0, 32'd20, 3'd6, 3'd7); step("R10 cmp");
        idle(); do_ex(3'd5, 32'hFFFF_FFF0, 32'd20, 4'd2, 3'd6); step("R10 then arm");
        do_ex(3'd6, 32'hFFFF_FFF0, 32'd20, 4'd2, 3'd7); step("R10 else arm");
        check("R10 result", wb_data, 32'd20);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            idle();
            if ($urandom_range(0, 3) != 0) begin
                logic [31:0] a, b;
                a = ($urandom_range(0, 2) == 0) ? edge_vals[$urandom_range(0, 5)] : $urandom();
                b = ($urandom_range(0, 3) == 0) ? a :
                    ($urandom_range(0, 2) == 0) ? edge_vals[$urandom_range(0, 5)] : $urandom();
                do_cmp(3'($urandom_range(0, 7)), a, b, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
            end
            if ($urandom_range(0, 3) != 0)
                do_ex(3'($urandom_range(0, 7)), $urandom(), $urandom(),
                      4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)));
            step("R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule